// File: doc/BRIEF.md
# Auto-Incrementing Pointer RAM Port

This block lets a host reach a 2048-byte buffer RAM indirectly, through a byte-wide register window. The host first loads an 11-bit pointer through two pointer registers. It then moves bytes through a single data register. The upper pointer register also carries two control bits: the direction of the data accesses that follow, and whether the pointer steps forward after each data access. The RAM is inside the block.

In the read direction, loading the lower pointer register fetches the addressed byte into a holding register. The next read of the data register returns that byte at once. With stepping enabled, each data read also advances the pointer and fetches the following byte, so a burst of reads streams through the buffer. Writes store at the pointer and step it in the same way. The pointer wraps from the top of the buffer back to zero.

The host drives one-cycle read and write strobes together with a register select. Read data is a combinational view of the selected register.

Top module: `ptrram_port`

## Requirements
- R1: After reset the pointer, the direction bit, the stepping bit and the holding register are all zero, so the upper, lower and data views all read 0x00.
- R2: Register select 0 is the upper pointer register, 1 is the lower pointer register and 2 is the data register. Select 3 reads as 0x00, and writes to it change nothing.
- R3: In the upper pointer register, bit 7 is the direction (1 = read, 0 = write), bit 6 enables stepping and bits 2..0 are pointer bits 10..8. Writing this register leaves pointer bits 7..0 unchanged.
- R4: Bits 5..3 of the upper pointer register always read as 0, whatever value was written to them.
- R5: A write to the lower pointer register loads pointer bits 7..0 and leaves bits 10..8 unchanged.
- R6: A lower-register write while the direction is read fetches the byte at the new pointer, and the next data read returns that byte. An upper-register write never fetches and leaves the holding register unchanged.
- R7: With stepping on and the direction read, a data read returns the held byte, adds one to the pointer and fetches the byte at the new pointer.
- R8: With stepping off, data accesses leave the pointer unchanged, so repeated data reads return the same byte.
- R9: A data write stores the byte at the pointer and steps the pointer when stepping is on. It never changes the holding register.
- R10: Stepping from pointer 0x7FF gives 0x000.
- R11: When the read and write strobes are both active, only the write takes effect, and the pointer steps at most once.
- R12: A data read in the write direction returns the held byte, fetches nothing and still steps the pointer when stepping is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 2 | Register select |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Combinational view of the selected register |

## Verification
The bench fills the whole buffer and then streams it back starting near the top, so the wrap from 0x7FF is exercised in both directions. A pointer that failed to wrap, or that carried into a wrong bit, would return a mismatching byte from the first wrapped address onward. Reads with stepping off check that the pointer truly holds; a design that still stepped would return neighbouring bytes. Two more groups of checks target the holding register and the strobes. The first covers an upper-register write in the read direction, a data write in the read direction and a data read in the write direction; a design that fetched in any of these cases would show a fresh byte where the old one is expected. The second drives both strobes at once; a design that honoured the read as well would step the pointer twice.

// File: rtl/ptrram_pkg.sv
package ptrram_pkg;
   typedef enum logic [1:0] {
      SEL_PTR_HI = 2'd0,
      SEL_PTR_LO = 2'd1,
      SEL_DATA   = 2'd2,
      SEL_NONE   = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/ptrram_decode.sv
module ptrram_decode
   import ptrram_pkg::*;
(
   input  reg_sel_e sel,
   input  logic     rd,
   input  logic     wr,
   output logic     hi_wr,
   output logic     lo_wr,
   output logic     dat_wr,
   output logic     dat_rd
);
   // write strobe wins over a simultaneous read strobe (R11)
   always_comb begin
      hi_wr  = wr && (sel == SEL_PTR_HI);
      lo_wr  = wr && (sel == SEL_PTR_LO);
      dat_wr = wr && (sel == SEL_DATA);
      dat_rd = rd && !wr && (sel == SEL_DATA);
   end
endmodule

// File: rtl/ptrram_ptr.sv
module ptrram_ptr #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hi_wr,
   input  logic              lo_wr,
   input  logic              dat_acc,
   input  logic [DATA_W-1:0] wdata,
   output logic [ADDR_W-1:0] ptr_q,
   output logic [ADDR_W-1:0] ptr_nxt,
   output logic              dir_rd,
   output logic              auto_inc,
   output logic [DATA_W-1:0] hi_view
);
   localparam int HIW     = ADDR_W - DATA_W;
   localparam int RSV_W   = DATA_W - 2 - HIW;
   localparam int DIR_BIT = DATA_W - 1;
   localparam int INC_BIT = DATA_W - 2;

   always_comb begin
      ptr_nxt = ptr_q;
      if (hi_wr)
         ptr_nxt[ADDR_W-1:DATA_W] = wdata[HIW-1:0];
      else if (lo_wr)
         ptr_nxt[DATA_W-1:0] = wdata;
      else if (dat_acc && auto_inc)
         ptr_nxt = ptr_q + ADDR_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q    <= '0;
         dir_rd   <= 1'b0;
         auto_inc <= 1'b0;
      end else begin
         ptr_q <= ptr_nxt;
         if (hi_wr) begin
            dir_rd   <= wdata[DIR_BIT];
            auto_inc <= wdata[INC_BIT];
         end
      end
   end

   generate
      if (RSV_W > 0) begin : g_rsv
         assign hi_view = {dir_rd, auto_inc, {RSV_W{1'b0}}, ptr_q[ADDR_W-1:DATA_W]};
      end else begin : g_norsv
         assign hi_view = {dir_rd, auto_inc, ptr_q[ADDR_W-1:DATA_W]};
      end
   endgenerate

   p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_acc && auto_inc) |=> ptr_q == ADDR_W'($past(ptr_q) + ADDR_W'(1)));
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_acc && !auto_inc) |=> $stable(ptr_q));
   p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_acc && auto_inc && (&ptr_q)) |=> ptr_q == '0);
   p_lo_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hi_wr |=> ptr_q[DATA_W-1:0] == $past(ptr_q[DATA_W-1:0]));
   p_hi_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lo_wr |=> ptr_q[ADDR_W-1:DATA_W] == $past(ptr_q[ADDR_W-1:DATA_W]));
endmodule

// File: rtl/ptrram_mem.sv
module ptrram_mem #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] hold_q
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  hold_q <= '0;
      else if (re) hold_q <= store[raddr];
   end

   p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !re |=> $stable(hold_q));
endmodule

// File: rtl/ptrram_port.sv
module ptrram_port
   import ptrram_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        host_sel,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata
);
   localparam int HIW   = ADDR_W - DATA_W;
   localparam int RSV_W = DATA_W - 2 - HIW;

   generate
      if (HIW < 1 || RSV_W < 0) begin : g_bad_cfg
         $error("ptrram_port: upper pointer bits must fit beside two control bits");
      end
   endgenerate

   reg_sel_e          sel;
   logic              hi_wr, lo_wr, dat_wr, dat_rd;
   logic [ADDR_W-1:0] ptr_q, ptr_nxt;
   logic              dir_rd, auto_inc;
   logic [DATA_W-1:0] hi_view, hold_q;
   logic              fetch;

   assign sel = reg_sel_e'(host_sel);

   ptrram_decode u_decode (
      .sel    (sel),
      .rd     (host_rd),
      .wr     (host_wr),
      .hi_wr  (hi_wr),
      .lo_wr  (lo_wr),
      .dat_wr (dat_wr),
      .dat_rd (dat_rd)
   );

   ptrram_ptr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .hi_wr    (hi_wr),
      .lo_wr    (lo_wr),
      .dat_acc  (dat_wr || dat_rd),
      .wdata    (host_wdata),
      .ptr_q    (ptr_q),
      .ptr_nxt  (ptr_nxt),
      .dir_rd   (dir_rd),
      .auto_inc (auto_inc),
      .hi_view  (hi_view)
   );

   // fetch at the pointer's next value so the byte is ready one cycle later
   assign fetch = dir_rd && (lo_wr || dat_rd);

   ptrram_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (dat_wr),
      .waddr  (ptr_q),
      .wdata  (host_wdata),
      .re     (fetch),
      .raddr  (ptr_nxt),
      .hold_q (hold_q)
   );

   always_comb begin
      unique case (sel)
         SEL_PTR_HI: host_rdata = hi_view;
         SEL_PTR_LO: host_rdata = ptr_q[DATA_W-1:0];
         SEL_DATA:   host_rdata = hold_q;
         default:    host_rdata = '0;
      endcase
   end

   generate
      if (RSV_W > 0) begin : g_rsv_chk
         always_comb begin
            if (rst_n && sel == SEL_PTR_HI)
               p_rsv_zero_r4: assert (host_rdata[DATA_W-3 -: RSV_W] == '0);
         end
      end
   endgenerate

   p_no_fetch_on_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir_rd || hi_wr || dat_wr) |=> $stable(hold_q));
endmodule

// File: tb/ptrram_port_tb.sv
module ptrram_port_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 2048;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] host_sel = 2'd3;
   logic       host_rd = 1'b0, host_wr = 1'b0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;
   logic [7:0] v;

   always #(CLK_PERIOD/2) clk = ~clk;

   ptrram_port u_dut (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_rd(host_rd),
      .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata)
   );

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 37) + ((a >> 8) * 11) + 5);
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   // one bus cycle, starting and ending on a falling edge; rdata sampled before the edge
   task automatic op(input logic [1:0] s, input logic r, input logic w,
                     input logic [7:0] d, output logic [7:0] q);
      host_sel = s; host_rd = r; host_wr = w; host_wdata = d;
      #1 q = host_rdata;
      @(posedge clk);
      @(negedge clk);
      host_rd = 1'b0; host_wr = 1'b0;
   endtask

   task automatic wreg(input logic [1:0] s, input logic [7:0] d);
      logic [7:0] q;
      op(s, 1'b0, 1'b1, d, q);
   endtask

   task automatic peek(input logic [1:0] s, output logic [7:0] q);
      op(s, 1'b0, 1'b0, 8'h00, q);
   endtask

   task automatic dread(output logic [7:0] q);
      op(2'd2, 1'b1, 1'b0, 8'h00, q);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      peek(2'd0, v); check("R1 upper", v, 8'h00);
      peek(2'd1, v); check("R1 lower", v, 8'h00);
      peek(2'd2, v); check("R1 data", v, 8'h00);

      // R2: select 3 reads zero, writes ignored
      wreg(2'd3, 8'hFF);
      peek(2'd3, v); check("R2 sel3 read", v, 8'h00);
      peek(2'd0, v); check("R2 upper untouched", v, 8'h00);
      peek(2'd1, v); check("R2 lower untouched", v, 8'h00);

      // R3/R4: fields, reserved bits read zero
      wreg(2'd1, 8'h5A);
      wreg(2'd0, 8'h7F);
      peek(2'd0, v); check("R4 reserved zero", v, 8'h47);
      peek(2'd1, v); check("R3 lower kept", v, 8'h5A);

      // R5 / R9 / R10: fill in write direction with stepping
      wreg(2'd0, 8'h40);
      wreg(2'd1, 8'h00);
      peek(2'd0, v); check("R5 upper kept", v, 8'h40);
      for (int a = 0; a < DEPTH; a++) wreg(2'd2, pat(a));
      peek(2'd1, v); check("R10 write wrap lower", v, 8'h00);
      peek(2'd0, v); check("R10 write wrap upper", v, 8'h40);
      peek(2'd2, v); check("R9 hold untouched by writes", v, 8'h00);

      // R6 / R7 / R10: stream from 0x7F0 across the wrap
      wreg(2'd0, 8'hC7);
      wreg(2'd1, 8'hF0);
      for (int i = 0; i < DEPTH; i++) begin
         dread(v);
         check("R7 stream byte", v, pat((16'h7F0 + i) & 16'h7FF));
      end
      peek(2'd1, v); check("R10 read wrap lower", v, 8'hF0);
      peek(2'd0, v); check("R10 read wrap upper", v, 8'hC7);

      // R8: no stepping on reads
      wreg(2'd0, 8'h82);
      wreg(2'd1, 8'h15);
      for (int i = 0; i < 4; i++) begin
         dread(v); check("R8 repeat read", v, pat(16'h215));
      end
      peek(2'd1, v); check("R8 pointer held", v, 8'h15);

      // R6: upper write does not fetch
      wreg(2'd0, 8'h81);
      peek(2'd1, v); check("R3 lower kept after upper", v, 8'h15);
      peek(2'd2, v); check("R6 no fetch on upper write", v, pat(16'h215));
      dread(v); check("R6 stale byte returned", v, pat(16'h215));
      dread(v); check("R8 refetch at held pointer", v, pat(16'h115));

      // R8 / R9: writes without stepping
      wreg(2'd0, 8'h03);
      wreg(2'd1, 8'h33);
      wreg(2'd2, 8'hAA);
      wreg(2'd2, 8'h55);
      peek(2'd1, v); check("R8 write pointer held", v, 8'h33);
      peek(2'd2, v); check("R9 hold kept", v, pat(16'h115));
      wreg(2'd0, 8'h83);
      wreg(2'd1, 8'h33);
      peek(2'd2, v); check("R8 last write kept", v, 8'h55);

      // R9: data write in read direction
      wreg(2'd0, 8'hC3);
      wreg(2'd1, 8'h40);
      wreg(2'd2, 8'h99);
      peek(2'd1, v); check("R9 write stepped", v, 8'h41);
      peek(2'd2, v); check("R9 hold not refreshed", v, pat(16'h340));

      // R12: data read in write direction
      wreg(2'd0, 8'h43);
      wreg(2'd1, 8'h50);
      dread(v); check("R12 returns held byte", v, pat(16'h340));
      peek(2'd2, v); check("R12 no fetch", v, pat(16'h340));
      peek(2'd1, v); check("R12 pointer stepped", v, 8'h51);

      // R11: both strobes
      wreg(2'd1, 8'h60);
      op(2'd2, 1'b1, 1'b1, 8'h77, v);
      peek(2'd1, v); check("R11 single step", v, 8'h61);
      peek(2'd2, v); check("R11 no fetch", v, pat(16'h340));
      wreg(2'd0, 8'h83);
      wreg(2'd1, 8'h60);
      peek(2'd2, v); check("R11 write landed", v, 8'h77);
      wreg(2'd1, 8'h40);
      peek(2'd2, v); check("R9 read-direction write landed", v, 8'h99);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule